// File: doc/BRIEF.md
# Interrupt Control Instruction Unit

This unit sits beside a small RISC-V core and executes a handful of interrupt-management instructions placed in the custom-0 major opcode. The core passes it each instruction word with a one-cycle valid strobe, the value of the rs1 operand and the current program counter. The unit keeps its own bank of four 32-bit scratch registers ("q-registers"), an interrupt mask and a record of pending interrupts fed by 32 request lines plus two fault events (illegal instruction and bus error).

Results come back one cycle after an instruction is accepted. They take the form of a destination-register write (address, value, enable), a program-counter redirect for the return-from-interrupt operation, a one-cycle pulse that hands the timer operation to a separate timer block, or an illegal-operation pulse. The unit also takes interrupt entry itself. When interrupts are enabled, the core presents no instruction and an unmasked interrupt is pending, it saves the current PC into q0 and the serviced bits into q1, clears those bits, disables interrupts and pulses an entry flag.

The unit is a three-state machine. RUN is the normal state. RUN goes to WAIT on a wait-for-interrupt instruction, and WAIT goes back to RUN once an unmasked interrupt is pending. Both RUN and WAIT go to HALT when a fault arrives while its interrupt is masked. HALT is left only by reset.

Top module: `irq_ctrl_unit`

## Requirements
- R1: An instruction is recognised only when bits [6:0] are 0001011 and bits [14:12] are 000. Bits [31:25] select the operation: 0000000 read-q, 0000001 write-q, 0000010 return, 0000011 swap-mask, 0000100 wait, 0000101 timer. A custom-0 word with nonzero bits [14:12] has no effect: it causes no write, no redirect and no flag.
- R2: Read-q writes q-register number instr[16:15] to destination register instr[11:7]. Write-q stores rs1_val into q-register number instr[8:7]. When the destination field is zero, the read-q, swap-mask and wait operations still complete but assert no rd_we.
- R3: Swap-mask returns the previous mask in rd_val and loads rs1_val as the new mask. A set mask bit disables that source. After reset the mask is all ones.
- R4: Return drives pc_redirect for one cycle with pc_target equal to q0, and it re-enables interrupt entry.
- R5: Wait raises stall from the next cycle and keeps it raised while no unmasked interrupt is pending. In the cycle after an unmasked bit becomes pending, stall falls and rd_val carries the unmasked pending bitmask. While stall is high, rd_we stays low.
- R6: A rising edge on irq_lines[i] sets pending bit i. Entry happens in RUN when no instruction is valid, interrupts are enabled and an unmasked bit is pending. On entry, q0 takes cur_pc, q1 takes the unmasked pending bits, those bits are cleared, interrupts are disabled and irq_entry pulses. Entry cannot happen again until a return.
- R7: A fault_ill pulse (source bit 1) or a fault_bus pulse (source bit 2) whose mask bit is set moves the unit to HALT. There trap stays high until reset and all instructions are ignored. If the mask bit is clear, the pulse sets the pending bit instead.
- R8: A custom-0 word with bits [14:12] of 000 and an unlisted bits [31:25] value pulses illegal_op and changes no state.
- R9: The timer operation pulses timer_op for one cycle and writes no destination register.
- R10: In any cycle at most one of rd_we, pc_redirect, illegal_op, timer_op and irq_entry is high. Each of them appears in the cycle after the instruction or entry that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | Value of the rs1 operand |
| cur_pc | input | 32 | Current program counter, saved on entry |
| irq_lines | input | 32 | Interrupt request lines, edge detected |
| fault_ill | input | 1 | Illegal-instruction event pulse |
| fault_bus | input | 1 | Bus-error event pulse |
| rd_we | output | 1 | Destination register write enable |
| rd_addr | output | 5 | Destination register index |
| rd_val | output | 32 | Destination register value |
| pc_redirect | output | 1 | Load the PC from pc_target |
| pc_target | output | 32 | Redirect target |
| stall | output | 1 | Core must hold fetch (WAIT state) |
| trap | output | 1 | Unit is halted (HALT state) |
| illegal_op | output | 1 | Unlisted custom-0 operation seen |
| timer_op | output | 1 | Timer operation handed off |
| irq_entry | output | 1 | Interrupt entry taken |

## Verification
The bench waits with a masked-off source quiet and then raises a line. A unit that releases the wait early would drop stall with an empty bitmask, and one that never checks pending would hang. It raises a line while entry is disabled and expects no entry until the return operation. An enable that is never restored would leave that interrupt untaken, while premature entry would overwrite q0. It sends an unlisted operation and a nonzero-funct3 word and reads the q-registers back afterwards, so a decoder that lets either write state is caught. A fault is raised both unmasked and masked, which tells pending-versus-halt confusion apart, and an instruction sent after halting shows whether the halt really blocks execution.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    typedef enum logic [2:0] {
        OP_GETQ, OP_SETQ, OP_RETIRQ, OP_MASKIRQ,
        OP_WAITIRQ, OP_TIMER, OP_BAD, OP_NONE
    } op_e;

    typedef enum logic [1:0] {
        ST_RUN, ST_WAIT, ST_HALT
    } state_e;

    localparam logic [6:0] CUSTOM0_OPC = 7'b0001011;
endpackage

// File: rtl/irq_ctrl_decode.sv
module irq_ctrl_decode
    import irq_ctrl_pkg::*;
#(
    parameter int QW = 2
) (
    input  logic [31:0]   instr,
    output op_e           op,
    output logic [4:0]    rd,
    output logic [QW-1:0] qsrc,
    output logic [QW-1:0] qdst
);
    logic unused_bits;
    assign unused_bits = ^{instr[24:20], instr[19:15]};

    assign rd   = instr[11:7];
    assign qsrc = instr[15 +: QW];
    assign qdst = instr[7 +: QW];

    always_comb begin
        op = OP_NONE;
        if (instr[6:0] == CUSTOM0_OPC && instr[14:12] == 3'b000) begin
            unique case (instr[31:25])
                7'b0000000: op = OP_GETQ;
                7'b0000001: op = OP_SETQ;
                7'b0000010: op = OP_RETIRQ;
                7'b0000011: op = OP_MASKIRQ;
                7'b0000100: op = OP_WAITIRQ;
                7'b0000101: op = OP_TIMER;
                default:    op = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/irq_qregs.sv
module irq_qregs #(
    parameter int XLEN = 32,
    parameter int NQ   = 4,
    localparam int QW  = $clog2(NQ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [QW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            entry_en,
    input  logic [XLEN-1:0] entry_q0,
    input  logic [XLEN-1:0] entry_q1,
    input  logic [QW-1:0]   rd_idx,
    output logic [XLEN-1:0] rd_data
);
    logic [XLEN-1:0] q [NQ];

    for (genvar i = 0; i < NQ; i++) begin : g_q
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= '0;
            end else if (entry_en && i == 0) begin
                q[i] <= entry_q0;
            end else if (entry_en && i == 1) begin
                q[i] <= entry_q1;
            end else if (wr_en && wr_idx == QW'(i)) begin
                q[i] <= wr_data;
            end
        end
    end

    assign rd_data = q[rd_idx];
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int NIRQ = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] lines,
    input  logic [NIRQ-1:0] extra_set,
    input  logic [NIRQ-1:0] clr,
    output logic [NIRQ-1:0] pending
);
    logic [NIRQ-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            pending <= '0;
        end else begin
            prev_q  <= lines;
            pending <= (pending & ~clr) | (lines & ~prev_q) | extra_set;
        end
    end
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
    import irq_ctrl_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NQ      = 4,
    parameter int ILL_BIT = 1,
    parameter int BUS_BIT = 2,
    localparam int QW     = $clog2(NQ),
    localparam int NIRQ   = XLEN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [NIRQ-1:0] irq_lines,
    input  logic            fault_ill,
    input  logic            fault_bus,
    output logic            rd_we,
    output logic [4:0]      rd_addr,
    output logic [XLEN-1:0] rd_val,
    output logic            pc_redirect,
    output logic [XLEN-1:0] pc_target,
    output logic            stall,
    output logic            trap,
    output logic            illegal_op,
    output logic            timer_op,
    output logic            irq_entry
);
    state_e          state_q, state_d;
    op_e             op;
    logic [4:0]      rd_f, wait_rd_q;
    logic [QW-1:0]   qsrc, qdst;
    logic [NIRQ-1:0] mask_q, pend, active, fault_set, pend_clr;
    logic [XLEN-1:0] q_rdata;
    logic            irq_en_q, go_halt, accept, take;

    irq_ctrl_decode #(.QW(QW)) u_dec (
        .instr(instr), .op(op), .rd(rd_f), .qsrc(qsrc), .qdst(qdst)
    );

    assign active  = pend & ~mask_q;
    assign go_halt = (state_q != ST_HALT) &&
                     ((fault_ill && mask_q[ILL_BIT]) || (fault_bus && mask_q[BUS_BIT]));
    assign accept  = (state_q == ST_RUN) && instr_valid && !go_halt;
    assign take    = (state_q == ST_RUN) && !instr_valid && irq_en_q && (|active) && !go_halt;

    always_comb begin
        fault_set = '0;
        fault_set[ILL_BIT] = fault_ill && !mask_q[ILL_BIT];
        fault_set[BUS_BIT] = fault_bus && !mask_q[BUS_BIT];
    end

    assign pend_clr = take ? active : '0;

    irq_pending #(.NIRQ(NIRQ)) u_pend (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines),
        .extra_set(fault_set), .clr(pend_clr), .pending(pend)
    );

    irq_qregs #(.XLEN(XLEN), .NQ(NQ)) u_q (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept && op == OP_SETQ), .wr_idx(qdst), .wr_data(rs1_val),
        .entry_en(take), .entry_q0(cur_pc), .entry_q1(active),
        .rd_idx(qsrc), .rd_data(q_rdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (go_halt)                        state_d = ST_HALT;
                else if (accept && op == OP_WAITIRQ) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (go_halt)      state_d = ST_HALT;
                else if (|active) state_d = ST_RUN;
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    assign stall = (state_q == ST_WAIT);
    assign trap  = (state_q == ST_HALT);

    // outputs and architectural state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_we       <= 1'b0;
            rd_addr     <= '0;
            rd_val      <= '0;
            pc_redirect <= 1'b0;
            pc_target   <= '0;
            illegal_op  <= 1'b0;
            timer_op    <= 1'b0;
            irq_entry   <= 1'b0;
            mask_q      <= '1;
            irq_en_q    <= 1'b1;
            wait_rd_q   <= '0;
        end else begin
            rd_we       <= 1'b0;
            pc_redirect <= 1'b0;
            illegal_op  <= 1'b0;
            timer_op    <= 1'b0;
            irq_entry   <= 1'b0;
            if (take) begin
                irq_entry <= 1'b1;
                irq_en_q  <= 1'b0;
            end
            if (accept) begin
                unique case (op)
                    OP_GETQ: begin
                        rd_we   <= (rd_f != '0);
                        rd_addr <= rd_f;
                        rd_val  <= q_rdata;
                    end
                    OP_MASKIRQ: begin
                        rd_we   <= (rd_f != '0);
                        rd_addr <= rd_f;
                        rd_val  <= mask_q;
                        mask_q  <= rs1_val;
                    end
                    OP_RETIRQ: begin
                        pc_redirect <= 1'b1;
                        pc_target   <= q_rdata_q0();
                        irq_en_q    <= 1'b1;
                    end
                    OP_WAITIRQ: wait_rd_q  <= rd_f;
                    OP_TIMER:   timer_op   <= 1'b1;
                    OP_BAD:     illegal_op <= 1'b1;
                    default: ;
                endcase
            end
            if (state_q == ST_WAIT && !go_halt && (|active)) begin
                rd_we   <= (wait_rd_q != '0);
                rd_addr <= wait_rd_q;
                rd_val  <= active;
            end
        end
    end

    function automatic logic [XLEN-1:0] q_rdata_q0();
        return u_q.q[0];
    endfunction
endmodule

// File: rtl/irq_ctrl_unit_chk.sv
module irq_ctrl_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_we,
    input logic [4:0] rd_addr,
    input logic [31:0] rd_val,
    input logic       pc_redirect,
    input logic       stall,
    input logic       trap,
    input logic       illegal_op,
    input logic       timer_op,
    input logic       irq_entry
);
    a_r2_no_write_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> rd_addr != 5'd0);

    a_r5_no_write_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !rd_we);

    a_r5_exit_carries_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stall) && !trap) |-> rd_val != 32'd0);

    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> trap);

    a_r7_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(trap) |-> !(rd_we || pc_redirect || timer_op || irq_entry || illegal_op));

    a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> !rd_we && !pc_redirect);

    a_r10_single_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_we, pc_redirect, illegal_op, timer_op, irq_entry}));
endmodule

bind irq_ctrl_unit irq_ctrl_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_we(rd_we), .rd_addr(rd_addr), .rd_val(rd_val),
    .pc_redirect(pc_redirect), .stall(stall), .trap(trap),
    .illegal_op(illegal_op), .timer_op(timer_op), .irq_entry(irq_entry)
);

// File: tb/irq_ctrl_unit_bench.sv
module irq_ctrl_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1_val = '0;
    logic [31:0] cur_pc = 32'h0000_0100;
    logic [31:0] irq_lines = '0;
    logic        fault_ill = 1'b0;
    logic        fault_bus = 1'b0;
    logic        rd_we, pc_redirect, stall, trap, illegal_op, timer_op, irq_entry;
    logic [4:0]  rd_addr;
    logic [31:0] rd_val, pc_target;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctrl_unit u_irq_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rs1_val(rs1_val), .cur_pc(cur_pc), .irq_lines(irq_lines),
        .fault_ill(fault_ill), .fault_bus(fault_bus),
        .rd_we(rd_we), .rd_addr(rd_addr), .rd_val(rd_val),
        .pc_redirect(pc_redirect), .pc_target(pc_target), .stall(stall),
        .trap(trap), .illegal_op(illegal_op), .timer_op(timer_op), .irq_entry(irq_entry)
    );

    function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] rs,
                                        input logic [2:0] f3, input logic [4:0] rd);
        return {f7, 5'd0, rs, f3, rd, 7'b0001011};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [31:0] rs);
        instr = w; rs1_val = rs; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk(!stall && !trap && !rd_we && !irq_entry, "R3 reset idle", {stall, trap, rd_we}, 0);
        issue(enc(7'b0000011, 5'd0, 3'b000, 5'd5), 32'h0);
        chk(rd_we && rd_addr == 5 && rd_val == 32'hFFFF_FFFF, "R3 reset mask all ones", rd_val, 32'hFFFF_FFFF);
    endtask

    task automatic t_qregs;
        issue(enc(7'b0000001, 5'd0, 3'b000, 5'd2), 32'hA5A5_1234);
        chk(!rd_we, "R2 setq writes no rd", rd_we, 0);
        issue(enc(7'b0000000, 5'd2, 3'b000, 5'd3), 32'h0);
        chk(rd_we && rd_addr == 3 && rd_val == 32'hA5A5_1234, "R2 getq value", rd_val, 32'hA5A5_1234);
        issue(enc(7'b0000000, 5'd2, 3'b000, 5'd0), 32'h0);
        chk(!rd_we, "R2 rd zero suppressed", rd_we, 0);
    endtask

    task automatic t_illegal;
        issue({7'b0000110, 5'd0, 5'd0, 3'b000, 5'd3, 7'b0001011}, 32'h0);
        chk(illegal_op && !rd_we, "R8 unlisted funct7 flagged", illegal_op, 1);
        issue(enc(7'b0000001, 5'd0, 3'b001, 5'd2), 32'hDEAD_BEEF);
        chk(!illegal_op && !rd_we && !pc_redirect, "R1 nonzero funct3 ignored", illegal_op, 0);
        issue(enc(7'b0000000, 5'd2, 3'b000, 5'd3), 32'h0);
        chk(rd_val == 32'hA5A5_1234, "R8 R1 q2 untouched", rd_val, 32'hA5A5_1234);
    endtask

    task automatic t_timer;
        issue(enc(7'b0000101, 5'd0, 3'b000, 5'd4), 32'd50);
        chk(timer_op && !rd_we, "R9 timer handed off", timer_op, 1);
        @(negedge clk);
        chk(!timer_op, "R9 timer single pulse", timer_op, 0);
    endtask

    task automatic t_wait;
        issue(enc(7'b0000100, 5'd0, 3'b000, 5'd7), 32'h0);
        chk(stall && !rd_we, "R5 stall raised", stall, 1);
        repeat (3) @(negedge clk);
        chk(stall, "R5 stall held", stall, 1);
        irq_lines[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!stall && rd_we && rd_addr == 7 && rd_val == 32'h20, "R5 wait returns bitmask", rd_val, 32'h20);
        @(negedge clk);
        chk(irq_entry, "R6 entry after wait", irq_entry, 1);
        issue(enc(7'b0000000, 5'd0, 3'b000, 5'd3), 32'h0);
        chk(rd_val == 32'h100, "R6 q0 holds pc", rd_val, 32'h100);
        issue(enc(7'b0000000, 5'd1, 3'b000, 5'd3), 32'h0);
        chk(rd_val == 32'h20, "R6 q1 holds taken bits", rd_val, 32'h20);
        irq_lines[5] = 1'b0;
    endtask

    task automatic t_return;
        irq_lines[6] = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!irq_entry, "R6 no entry while disabled", irq_entry, 0);
        end
        cur_pc = 32'h200;
        issue(enc(7'b0000010, 5'd0, 3'b000, 5'd0), 32'h0);
        chk(pc_redirect && pc_target == 32'h100, "R4 return target q0", pc_target, 32'h100);
        @(negedge clk);
        chk(irq_entry, "R4 entry re-enabled", irq_entry, 1);
        issue(enc(7'b0000000, 5'd1, 3'b000, 5'd3), 32'h0);
        chk(rd_val == 32'h40, "R6 second q1", rd_val, 32'h40);
        irq_lines[6] = 1'b0;
        issue(enc(7'b0000010, 5'd0, 3'b000, 5'd0), 32'h0);
        chk(pc_redirect && pc_target == 32'h200, "R4 return to saved pc", pc_target, 32'h200);
    endtask

    task automatic t_mask;
        issue(enc(7'b0000011, 5'd0, 3'b000, 5'd4), 32'h0000_00F0);
        chk(rd_val == 32'h0, "R3 old mask zero", rd_val, 0);
        issue(enc(7'b0000011, 5'd0, 3'b000, 5'd4), 32'hFFFF_FFFF);
        chk(rd_val == 32'hF0, "R3 old mask returned", rd_val, 32'hF0);
        issue(enc(7'b0000011, 5'd0, 3'b000, 5'd4), ~32'h2);
        chk(rd_val == 32'hFFFF_FFFF, "R3 mask all set", rd_val, 32'hFFFF_FFFF);
    endtask

    task automatic t_faults;
        fault_ill = 1'b1;
        @(negedge clk);
        fault_ill = 1'b0;
        chk(!trap, "R7 unmasked fault no halt", trap, 0);
        @(negedge clk);
        chk(irq_entry, "R7 unmasked fault entry", irq_entry, 1);
        issue(enc(7'b0000000, 5'd1, 3'b000, 5'd3), 32'h0);
        chk(rd_val == 32'h2, "R7 fault pending bit 1", rd_val, 32'h2);
        issue(enc(7'b0000010, 5'd0, 3'b000, 5'd0), 32'h0);
        fault_bus = 1'b1;
        @(negedge clk);
        fault_bus = 1'b0;
        chk(trap, "R7 masked fault halts", trap, 1);
        issue(enc(7'b0000000, 5'd1, 3'b000, 5'd3), 32'h0);
        chk(trap && !rd_we, "R7 halted ignores instr", rd_we, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_qregs();
        t_illegal();
        t_timer();
        t_wait();
        t_return();
        t_mask();
        t_faults();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=hang expected=finish");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule